// File: doc/BRIEF.md
# Vector Length Computation Unit

This block works out the effective vector length for a set-vector-length operation. It takes three inputs: the two-bit element-width code of the selected register, a vector length configured for that register, and a length requested through a source register. From the width code it finds how many bytes one element occupies. From that figure it derives a packing multiplier: the number of elements that share one register. The configured length is multiplied by this factor. The product is then limited twice, first by a fixed maximum depth and then by the request.

A one-cycle start strobe loads the result into an output register. A done pulse marks the cycle in which that new value can be read. The output holds its value until the next start.

The sequencing is a two-state machine. ST_IDLE waits for a strobe. ST_DONE is the one cycle in which done is raised. The transitions are:
- "launch": from ST_IDLE to ST_DONE when start is high.
- "rearm": from ST_DONE to ST_DONE when start is high again.
- "settle": from ST_DONE to ST_IDLE when start is low.
- "wait": from ST_IDLE to ST_IDLE when start is low.

Top module: `vl_unit`

## Requirements
- R1: While reset is asserted and after it is released without a start, `vl_o` is 0 and `done_o` is 0.
- R2: `done_o` is 1 in exactly the cycle after each cycle in which `start_i` is 1, and 0 otherwise.
- R3: Width code 0 gives elements of XLEN/8 bytes, so the packing multiplier is 1.
- R4: Width code 1 gives elements of XLEN/4 bytes. The quotient (XLEN/8)/(XLEN/4) is 0, so the multiplier is forced to 1.
- R5: Width code 2 gives elements of TBL2_BYTES bytes (default 8) and code 3 gives elements of TBL3_BYTES bytes (default 16). The multiplier is (XLEN/8)/bytes using integer division, and it is raised to 1 when the quotient is 0.
- R6: The loaded length equals min(min(cfg_len_i × multiplier, MAX_DEPTH), req_len_i), using the inputs sampled in the start cycle.
- R7: A requested length of 0 always loads a length of 0.
- R8: Without `start_i`, changes on the width, configured-length and request inputs have no effect on `vl_o`.
- R9: Starts on consecutive cycles each load their own result, and `done_o` stays 1 across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that launches a computation |
| width_code_i | input | 2 | Element-width code of the selected register |
| cfg_len_i | input | CFG_W | Vector length configured for the register |
| req_len_i | input | LEN_W | Requested length from the source register |
| vl_o | output | LEN_W | Registered effective vector length |
| done_o | output | 1 | High for one cycle after each start |

## Verification
Every result of this block is due one clock edge after the start strobe is sampled. The length and the done pulse both become valid in the cycle that follows the strobe. The bench drives inputs on the falling edge and samples both outputs on the next falling edge, so each check lands exactly in the cycle the result is due. Hold checks change the inputs without a strobe and look again one cycle later. Back-to-back checks sample once per strobe, one cycle after each.

// File: rtl/vl_pkg.sv
package vl_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } vl_state_e;

    typedef logic [1:0] ew_code_t;

    localparam int unsigned EW_CODES = 4;

    // Bytes per element for a given width code.
    function automatic int unsigned ew_bytes(input int unsigned code,
                                             input int unsigned xlen,
                                             input int unsigned tbl2,
                                             input int unsigned tbl3);
        int unsigned b;
        case (code)
            0:       b = xlen / 8;
            1:       b = xlen / 4;
            2:       b = tbl2;
            default: b = tbl3;
        endcase
        return b;
    endfunction

    // Packing multiplier, never below one.
    function automatic int unsigned ew_mult(input int unsigned code,
                                            input int unsigned xlen,
                                            input int unsigned tbl2,
                                            input int unsigned tbl3);
        int unsigned q;
        q = (xlen / 8) / ew_bytes(code, xlen, tbl2, tbl3);
        if (q == 0) q = 1;
        return q;
    endfunction

endpackage

// File: rtl/vl_pack_factor.sv
module vl_pack_factor
    import vl_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned TBL2_BYTES = 8,
    parameter int unsigned TBL3_BYTES = 16,
    parameter int unsigned MULT_W     = 4
) (
    input  ew_code_t            code_i,
    output logic [MULT_W-1:0]   mult_o
);

    logic [MULT_W-1:0] mult_tbl [EW_CODES];

    // One constant entry per width code; the code only selects.
    for (genvar gc = 0; gc < EW_CODES; gc++) begin : g_tbl
        localparam int unsigned M = ew_mult(gc, XLEN, TBL2_BYTES, TBL3_BYTES);
        assign mult_tbl[gc] = MULT_W'(M);
    end

    always_comb begin
        mult_o = mult_tbl[code_i];
    end

endmodule

// File: rtl/vl_scale_clamp.sv
module vl_scale_clamp #(
    parameter int unsigned CFG_W     = 8,
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned MULT_W    = 4,
    parameter int unsigned MAX_DEPTH = 64
) (
    input  logic [CFG_W-1:0]  cfg_len_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [LEN_W-1:0]  req_len_i,
    output logic [LEN_W-1:0]  len_o
);

    localparam int unsigned SCL_W = CFG_W + MULT_W;
    localparam int unsigned CMP_W = (SCL_W > LEN_W) ? SCL_W + 1 : LEN_W + 1;

    logic [SCL_W-1:0] scaled;
    logic [CMP_W-1:0] scaled_w;
    logic [CMP_W-1:0] depth_lim;
    logic [CMP_W-1:0] req_w;
    logic [CMP_W-1:0] final_w;

    always_comb begin
        scaled    = SCL_W'(cfg_len_i) * SCL_W'(mult_i);
        scaled_w  = CMP_W'(scaled);
        req_w     = CMP_W'(req_len_i);
        // first level: fixed depth ceiling
        depth_lim = (scaled_w > CMP_W'(MAX_DEPTH)) ? CMP_W'(MAX_DEPTH) : scaled_w;
        // second level: caller's request
        final_w   = (depth_lim > req_w) ? req_w : depth_lim;
        len_o     = final_w[LEN_W-1:0];
    end

endmodule

// File: rtl/vl_seq_ctrl.sv
module vl_seq_ctrl
    import vl_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [LEN_W-1:0] vl_o,
    output logic             done_o
);

    vl_state_e state_q, state_d;
    logic [LEN_W-1:0] vl_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch, rearm, settle, wait
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start_i ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start_i ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       vl_q <= '0;
        else if (start_i) vl_q <= len_i;
    end

    always_comb begin
        vl_o   = vl_q;
        done_o = (state_q == ST_DONE);
    end

endmodule

// File: rtl/vl_unit.sv
module vl_unit
    import vl_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned TBL2_BYTES = 8,
    parameter int unsigned TBL3_BYTES = 16,
    parameter int unsigned CFG_W      = 8,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned MAX_DEPTH  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       width_code_i,
    input  logic [CFG_W-1:0] cfg_len_i,
    input  logic [LEN_W-1:0] req_len_i,
    output logic [LEN_W-1:0] vl_o,
    output logic             done_o
);

    localparam int unsigned MULT_W = $clog2(XLEN / 8 + 1);

    logic [MULT_W-1:0] mult;
    logic [LEN_W-1:0]  len_comb;

    vl_pack_factor #(
        .XLEN(XLEN), .TBL2_BYTES(TBL2_BYTES), .TBL3_BYTES(TBL3_BYTES), .MULT_W(MULT_W)
    ) u_pack (
        .code_i (width_code_i),
        .mult_o (mult)
    );

    vl_scale_clamp #(
        .CFG_W(CFG_W), .LEN_W(LEN_W), .MULT_W(MULT_W), .MAX_DEPTH(MAX_DEPTH)
    ) u_clamp (
        .cfg_len_i (cfg_len_i),
        .mult_i    (mult),
        .req_len_i (req_len_i),
        .len_o     (len_comb)
    );

    vl_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .len_i   (len_comb),
        .vl_o    (vl_o),
        .done_o  (done_o)
    );

endmodule

// File: rtl/vl_unit_chk.sv
module vl_unit_chk #(
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned MAX_DEPTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [LEN_W-1:0] req_len_i,
    input logic [LEN_W-1:0] vl_o,
    input logic             done_o
);

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o); // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o); // R2
    AST_DEPTH_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (32'(vl_o) <= MAX_DEPTH)); // R6
    AST_REQ_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (vl_o <= $past(req_len_i))); // R6
    AST_ZERO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && req_len_i == '0) |=> (vl_o == '0)); // R7
    AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(vl_o)); // R8

endmodule

bind vl_unit vl_unit_chk #(.LEN_W(LEN_W), .MAX_DEPTH(MAX_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .req_len_i (req_len_i),
    .vl_o      (vl_o),
    .done_o    (done_o)
);

// File: tb/tb_vl_unit.sv
module tb_vl_unit;

    localparam int CLK_PERIOD = 10;
    localparam int CFG_W = 8;
    localparam int LEN_W = 16;
    localparam int XA = 64,  DA = 64;
    localparam int XB = 256, DB = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] code = '0;
    logic [CFG_W-1:0] cfg = '0;
    logic [LEN_W-1:0] req = '0;
    logic [LEN_W-1:0] vl_a, vl_b;
    logic done_a, done_b;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vl_unit #(.XLEN(XA), .MAX_DEPTH(DA)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .width_code_i(code),
        .cfg_len_i(cfg), .req_len_i(req), .vl_o(vl_a), .done_o(done_a));

    vl_unit #(.XLEN(XB), .MAX_DEPTH(DB)) dut_w (
        .clk(clk), .rst_n(rst_n), .start_i(start), .width_code_i(code),
        .cfg_len_i(cfg), .req_len_i(req), .vl_o(vl_b), .done_o(done_b));

    function automatic int exp_mult(int xlen, int c);
        int b, m;
        case (c)
            0: b = xlen / 8;
            1: b = xlen / 4;
            2: b = 8;
            default: b = 16;
        endcase
        m = (xlen / 8) / b;
        return (m < 1) ? 1 : m;
    endfunction

    function automatic int exp_vl(int xlen, int depth, int c, int cf, int rq);
        int s;
        s = cf * exp_mult(xlen, c);
        if (s > depth) s = depth;
        if (s > rq) s = rq;
        return s;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string code_tag(int c);
        case (c)
            0: return "R3 R6";
            1: return "R4 R6";
            default: return "R5 R6";
        endcase
    endfunction

    // one strobed computation, checked one cycle later on both units
    task automatic run(int c, int cf, int rq);
        @(negedge clk);
        code = 2'(c); cfg = CFG_W'(cf); req = LEN_W'(rq); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 done", int'(done_a), 1);
        check(rq == 0 ? "R7 zero" : code_tag(c), int'(vl_a), exp_vl(XA, DA, c, cf, rq));
        check(rq == 0 ? "R7 zero wide" : code_tag(c), int'(vl_b), exp_vl(XB, DB, c, cf, rq));
    endtask

    initial begin
        int unsigned seed;
        int prev_a, prev_b;
        seed = $urandom(32'd4242);
        // R1 reset state
        #(CLK_PERIOD * 2 + 1);
        check("R1 vl in reset", int'(vl_a), 0);
        check("R1 done in reset", int'(done_a), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 vl after reset", int'(vl_b), 0);
        check("R1 done after reset", int'(done_b), 0);

        // directed corners per code
        run(0, 10, 100);   // R3
        run(0, 200, 300);  // R3 depth clamp
        run(1, 30, 100);   // R4 forced multiplier
        run(2, 30, 500);   // R5 x4 on wide unit
        run(3, 30, 500);   // R5 x2 on wide unit
        run(2, 255, 1000); // R6 depth ceiling
        run(3, 40, 7);     // R6 request ceiling
        run(2, 100, 0);    // R7
        run(0, 0, 50);     // zero configured length

        // R2 done falls without start
        @(negedge clk);
        check("R2 done low", int'(done_a), 0);

        // R8 hold: inputs change without strobe
        prev_a = int'(vl_a); prev_b = int'(vl_b);
        code = 2'd2; cfg = 8'd99; req = 16'd999;
        @(negedge clk);
        code = 2'd0; cfg = 8'd1; req = 16'd1;
        @(negedge clk);
        check("R8 hold", int'(vl_a), prev_a);
        check("R8 hold wide", int'(vl_b), prev_b);

        // R9 back-to-back starts
        @(negedge clk);
        code = 2'd2; cfg = 8'd20; req = 16'd300; start = 1'b1;
        @(negedge clk);
        check("R9 first", int'(vl_b), exp_vl(XB, DB, 2, 20, 300));
        code = 2'd3; cfg = 8'd50; req = 16'd60;
        @(negedge clk);
        start = 1'b0;
        check("R9 second", int'(vl_b), exp_vl(XB, DB, 3, 50, 60));
        check("R9 done held", int'(done_b), 1);

        // constrained random
        for (int i = 0; i < 200; i++) begin
            int c, cf, rq;
            c  = int'($urandom_range(3, 0));
            cf = int'($urandom_range(255, 0));
            rq = ($urandom_range(7, 0) == 0) ? 0 : int'($urandom_range(400, 0));
            run(c, cf, rq);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule